// File: doc/BRIEF.md
# Vector Register Byte-Lane Move Unit

This unit moves 16-bit quantities between the scalar side of a processor and a file of wide vector registers. It also gives the scalar side read and write access to a small bank of 16-bit vector control flags. An operation arrives as an operation code, a vector register index, a 4-bit byte position, a flag index, a scalar destination index and the low half of a scalar source value. When the operation is complete, the unit presents a 32-bit scalar result, a destination index and a write enable for the scalar register file.

The byte position is a byte offset, not a halfword index. A 16-bit value occupies the byte at that position and the byte after it. The second byte wraps around to byte 0 after byte 15. The two bytes are combined big-endian, and byte 0 is the most significant byte of the vector register.

A state machine sequences each operation. The states are:
- `ST_IDLE`: waits for work with `ready` high.
- `ST_VGET`: extracts bytes from a vector register.
- `ST_VPUT`: writes bytes into a vector register.
- `ST_FGET`: reads a flag.
- `ST_FPUT`: writes a flag.
- `ST_DONE`: presents the result.

The transitions are:
- `ST_IDLE` to the state that matches the operation code, when `op_valid` is high and the code is legal.
- Each of the four work states to `ST_DONE`, unconditionally.
- `ST_DONE` to `ST_IDLE`, unconditionally.
- `ST_IDLE` to `ST_IDLE` in all other cases.

Top module: `vlane_xfer`

## Requirements
- R1: After reset, `ready` is 1, `done`, `res_we` and `res_data` are 0, and every vector register byte and every flag reads as zero.
- R2: The operation codes are 0 for move-out, 2 for flag read, 4 for move-in and 6 for flag write. The unit accepts an operation on a clock edge where `op_valid` and `ready` are both high. `ready` is then low for two cycles, and `done` is high for exactly the second of them. Any other code is ignored: `ready` stays high and `done` stays low.
- R3: Move-out forms a 16-bit value whose upper byte is byte `e` of the register and whose lower byte is byte `(e+1) mod 16`. Byte 0 is bits 127:120 of the register.
- R4: The move-out result is sign-extended from bit 15 to 32 bits on `res_data`.
- R5: A move-out or flag read whose destination index is 0 drives `res_we` low. With any other destination index, it drives `res_we` high and `res_dst` equal to that index.
- R6: Move-in writes `scalar_lo[15:8]` to byte `e` and `scalar_lo[7:0]` to byte `(e+1) mod 16`. All other bytes of that register, and all other registers, are unchanged.
- R7: Move-in with `e` = 15 writes the upper byte to byte 15 and the lower byte to byte 0.
- R8: A flag write stores the 16 bits of `scalar_lo` into the selected flag.
- R9: A flag read returns the flag zero-extended to 32 bits.
- R10: Flag indices 0 to 3 are valid. A read of any other index returns 0, and a write to any other index changes no flag.
- R11: Move-in and flag write complete with `done` high and `res_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 5 | Operation code (0, 2, 4 or 6) |
| vreg_idx | input | 5 | Vector register index |
| byte_sel | input | 4 | Byte position `e` within the vector register |
| flag_idx | input | 5 | Flag index |
| dst_idx | input | 5 | Scalar destination index |
| scalar_lo | input | 16 | Low half of the scalar source value |
| ready | output | 1 | Unit is idle and accepts an operation |
| done | output | 1 | One-cycle completion strobe |
| res_we | output | 1 | Scalar write enable, valid while `done` is high |
| res_dst | output | 5 | Scalar destination index |
| res_data | output | 32 | Scalar result |

## Verification
The bench aims at the wrap from byte 15 to byte 0. A design that ignores the wrap would take its lower byte from outside the register, or would corrupt a neighbouring byte. It also aims at values with bit 15 set. Move-out must sign-extend these, while a flag read must zero-extend them, so swapping or merging the two extensions would show in the upper result half. Writes to destination 0 and to out-of-range flag indices are checked through later reads of every flag. Runs of random move-ins that overlap on a few registers expose any write that disturbs bytes it should leave alone.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
    localparam int HALF_W = 16;
    localparam int SCAL_W = 32;

    typedef enum logic [4:0] {
        OPC_VGET = 5'd0,
        OPC_FGET = 5'd2,
        OPC_VPUT = 5'd4,
        OPC_FPUT = 5'd6
    } opc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VGET,
        ST_VPUT,
        ST_FGET,
        ST_FPUT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/vlane_vfile.sv
module vlane_vfile #(
    parameter int NVREG = 32,
    parameter int VW    = 128,
    localparam int LANES = VW / 8,
    localparam int BW    = $clog2(LANES),
    localparam int IW    = $clog2(NVREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic [BW-1:0] pos,
    input  logic          wr_en,
    input  logic [15:0]   wr_half,
    output logic [15:0]   rd_half
);
    logic [VW-1:0] mem [NVREG];
    logic [BW-1:0] pos_nx;
    logic [VW-1:0] row;

    // Second byte of the pair wraps within the register.
    assign pos_nx = pos + BW'(1);
    assign row    = mem[idx];

    // Byte 0 occupies the most significant byte of the register.
    always_comb begin
        rd_half[15:8] = row[(LANES-1-int'(pos))*8 +: 8];
        rd_half[7:0]  = row[(LANES-1-int'(pos_nx))*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NVREG; r++) mem[r] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (BW'(b) == pos)
                    mem[idx][(LANES-1-b)*8 +: 8] <= wr_half[15:8];
                else if (BW'(b) == pos_nx)
                    mem[idx][(LANES-1-b)*8 +: 8] <= wr_half[7:0];
            end
        end
    end
endmodule

// File: rtl/vlane_flags.sv
module vlane_flags #(
    parameter int NFLAG = 4,
    parameter int FIW   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [FIW-1:0] idx,
    input  logic           wr_en,
    input  logic [15:0]    wr_val,
    output logic [15:0]    rd_val
);
    logic [15:0] flag_q [NFLAG];
    logic        in_range;

    assign in_range = int'(idx) < NFLAG;

    always_comb begin
        rd_val = '0;
        for (int f = 0; f < NFLAG; f++)
            if (in_range && int'(idx) == f) rd_val = flag_q[f];
    end

    generate
        for (genvar f = 0; f < NFLAG; f++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q[f] <= '0;
                else if (wr_en && in_range && int'(idx) == f)
                    flag_q[f] <= wr_val;
            end
        end
    endgenerate
endmodule

// File: rtl/vlane_fsm.sv
module vlane_fsm
    import vlane_pkg::*;
#(
    parameter int IW  = 5,
    parameter int BW  = 4,
    parameter int FIW = 5,
    parameter int DW  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [4:0]          op_code,
    input  logic [IW-1:0]       vreg_idx,
    input  logic [BW-1:0]       byte_sel,
    input  logic [FIW-1:0]      flag_idx,
    input  logic [DW-1:0]       dst_idx,
    input  logic [HALF_W-1:0]   scalar_lo,
    input  logic [HALF_W-1:0]   vf_half,
    input  logic [HALF_W-1:0]   fl_half,
    output logic [IW-1:0]       vf_idx,
    output logic [BW-1:0]       vf_pos,
    output logic                vf_wr,
    output logic [FIW-1:0]      fl_idx,
    output logic                fl_wr,
    output logic [HALF_W-1:0]   wr_half,
    output logic                ready,
    output logic                done,
    output logic                res_we,
    output logic [DW-1:0]       res_dst,
    output logic [SCAL_W-1:0]   res_data
);
    state_e              state_q, state_d;
    logic [IW-1:0]       cap_vreg;
    logic [BW-1:0]       cap_pos;
    logic [FIW-1:0]      cap_flag;
    logic [DW-1:0]       cap_dst;
    logic [HALF_W-1:0]   cap_half;
    logic                accept;

    assign accept = op_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OPC_VGET: state_d = ST_VGET;
                        OPC_VPUT: state_d = ST_VPUT;
                        OPC_FGET: state_d = ST_FGET;
                        OPC_FPUT: state_d = ST_FPUT;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_VGET, ST_VPUT, ST_FGET, ST_FPUT: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vreg <= '0;
            cap_pos  <= '0;
            cap_flag <= '0;
            cap_dst  <= '0;
            cap_half <= '0;
        end else if (accept) begin
            cap_vreg <= vreg_idx;
            cap_pos  <= byte_sel;
            cap_flag <= flag_idx;
            cap_dst  <= dst_idx;
            cap_half <= scalar_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_we   <= 1'b0;
            res_dst  <= '0;
            res_data <= '0;
        end else begin
            unique case (state_q)
                ST_VGET: begin
                    res_data <= {{(SCAL_W-HALF_W){vf_half[HALF_W-1]}}, vf_half};
                    res_we   <= (cap_dst != '0);
                    res_dst  <= cap_dst;
                end
                ST_FGET: begin
                    res_data <= {{(SCAL_W-HALF_W){1'b0}}, fl_half};
                    res_we   <= (cap_dst != '0);
                    res_dst  <= cap_dst;
                end
                ST_VPUT, ST_FPUT: begin
                    res_data <= '0;
                    res_we   <= 1'b0;
                    res_dst  <= '0;
                end
                ST_IDLE, ST_DONE: begin
                    res_we   <= 1'b0;
                end
                default: res_we <= 1'b0;
            endcase
        end
    end

    assign ready   = (state_q == ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign vf_idx  = cap_vreg;
    assign vf_pos  = cap_pos;
    assign vf_wr   = (state_q == ST_VPUT);
    assign fl_idx  = cap_flag;
    assign fl_wr   = (state_q == ST_FPUT);
    assign wr_half = cap_half;
endmodule

// File: rtl/vlane_xfer.sv
module vlane_xfer
    import vlane_pkg::*;
#(
    parameter int NVREG = 32,
    parameter int VW    = 128,
    parameter int NFLAG = 4,
    localparam int IW   = $clog2(NVREG),
    localparam int BW   = $clog2(VW / 8),
    localparam int FIW  = 5,
    localparam int DW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [IW-1:0]     vreg_idx,
    input  logic [BW-1:0]     byte_sel,
    input  logic [FIW-1:0]    flag_idx,
    input  logic [DW-1:0]     dst_idx,
    input  logic [15:0]       scalar_lo,
    output logic              ready,
    output logic              done,
    output logic              res_we,
    output logic [DW-1:0]     res_dst,
    output logic [31:0]       res_data
);
    logic [IW-1:0]     vf_idx;
    logic [BW-1:0]     vf_pos;
    logic              vf_wr;
    logic [FIW-1:0]    fl_idx;
    logic              fl_wr;
    logic [15:0]       wr_half;
    logic [15:0]       vf_half;
    logic [15:0]       fl_half;

    vlane_fsm #(.IW(IW), .BW(BW), .FIW(FIW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .vreg_idx(vreg_idx), .byte_sel(byte_sel), .flag_idx(flag_idx),
        .dst_idx(dst_idx), .scalar_lo(scalar_lo), .vf_half(vf_half),
        .fl_half(fl_half), .vf_idx(vf_idx), .vf_pos(vf_pos), .vf_wr(vf_wr),
        .fl_idx(fl_idx), .fl_wr(fl_wr), .wr_half(wr_half), .ready(ready),
        .done(done), .res_we(res_we), .res_dst(res_dst), .res_data(res_data)
    );

    vlane_vfile #(.NVREG(NVREG), .VW(VW)) u_vfile (
        .clk(clk), .rst_n(rst_n), .idx(vf_idx), .pos(vf_pos),
        .wr_en(vf_wr), .wr_half(wr_half), .rd_half(vf_half)
    );

    vlane_flags #(.NFLAG(NFLAG), .FIW(FIW)) u_flags (
        .clk(clk), .rst_n(rst_n), .idx(fl_idx), .wr_en(fl_wr),
        .wr_val(wr_half), .rd_val(fl_half)
    );
endmodule

// File: rtl/vlane_xfer_chk.sv
module vlane_xfer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [4:0]  op_code,
    input logic        ready,
    input logic        done,
    input logic        res_we,
    input logic [4:0]  res_dst,
    input logic [31:0] res_data
);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ready && !op_code[0] && op_code[4:3] == 2'b00)
        |=> (!ready && !done));

    // R2
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ready && (op_code[0] || op_code[4:3] != 2'b00))
        |=> ready);

    // R5
    no_zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> (res_dst != 5'd0));

    // R11
    we_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> done);

    // R4
    upper_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_data[31:16] != 16'h0)
        |-> (res_data[31:16] == 16'hFFFF && res_data[15]));
endmodule

bind vlane_xfer vlane_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ready(ready), .done(done), .res_we(res_we), .res_dst(res_dst),
    .res_data(res_data)
);

// File: tb/vlane_xfer_tb.sv
module vlane_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [4:0]  vreg_idx = '0;
    logic [3:0]  byte_sel = '0;
    logic [4:0]  flag_idx = '0;
    logic [4:0]  dst_idx = '0;
    logic [15:0] scalar_lo = '0;
    logic        ready, done, res_we;
    logic [4:0]  res_dst;
    logic [31:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [127:0] mdl [32];
    logic [15:0]  mflag [4];

    always #10 clk = ~clk;

    vlane_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .vreg_idx(vreg_idx), .byte_sel(byte_sel), .flag_idx(flag_idx),
        .dst_idx(dst_idx), .scalar_lo(scalar_lo), .ready(ready), .done(done),
        .res_we(res_we), .res_dst(res_dst), .res_data(res_data)
    );

    function automatic logic [7:0] byte_of(logic [127:0] row, logic [3:0] b);
        return row[(15 - int'(b)) * 8 +: 8];
    endfunction

    function automatic logic [15:0] half_of(logic [127:0] row, logic [3:0] e);
        return {byte_of(row, e), byte_of(row, e + 4'd1)};
    endfunction

    function automatic logic [127:0] put_half(logic [127:0] row, logic [3:0] e,
                                              logic [15:0] v);
        logic [127:0] r = row;
        logic [3:0] e1 = e + 4'd1;
        r[(15 - int'(e)) * 8 +: 8]  = v[15:8];
        r[(15 - int'(e1)) * 8 +: 8] = v[7:0];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One operation; returns after the unit is idle again.
    task automatic run_op(input logic [4:0] code, input logic [4:0] vr,
                          input logic [3:0] e, input logic [4:0] fi,
                          input logic [4:0] dst, input logic [15:0] val);
        logic [31:0] exp_d;
        bit exp_we;
        bit legal = (code == 5'd0 || code == 5'd2 || code == 5'd4 || code == 5'd6);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; vreg_idx = vr; byte_sel = e;
        flag_idx = fi; dst_idx = dst; scalar_lo = val;
        @(negedge clk);
        op_valid = 1'b0;
        chk(ready == !legal, "R2 ready after accept", {31'b0, ready}, {31'b0, !legal});
        @(negedge clk);
        chk(done == legal, "R2 done strobe", {31'b0, done}, {31'b0, legal});
        if (legal) begin
            exp_d = '0; exp_we = 1'b0;
            case (code)
                5'd0: begin
                    exp_d = {{16{half_of(mdl[vr], e)[15]}}, half_of(mdl[vr], e)};
                    exp_we = (dst != 0);
                    chk(res_data == exp_d, "R3/R4 move-out value", res_data, exp_d);
                end
                5'd2: begin
                    exp_d = (fi < 5'd4) ? {16'h0, mflag[fi[1:0]]} : 32'h0;
                    exp_we = (dst != 0);
                    chk(res_data == exp_d, "R9/R10 flag read value", res_data, exp_d);
                end
                5'd4: mdl[vr] = put_half(mdl[vr], e, val);
                default: if (fi < 5'd4) mflag[fi[1:0]] = val;
            endcase
            chk(res_we == exp_we, "R5/R11 write enable", {31'b0, res_we}, {31'b0, exp_we});
            if (exp_we)
                chk(res_dst == dst, "R5 destination", {27'b0, res_dst}, {27'b0, dst});
            @(negedge clk);
            chk(!done && ready, "R2 back to idle", {30'b0, done, ready}, 32'h1);
        end else begin
            @(negedge clk);
            chk(ready, "R2 illegal code ignored", {31'b0, ready}, 32'h1);
        end
    endtask

    task automatic read_flags_all();
        for (int f = 0; f < 4; f++) run_op(5'd2, 5'd0, 4'd0, 5'(f), 5'd3, 16'h0);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        for (int f = 0; f < 4; f++) mflag[f] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready && !done && !res_we && res_data == 0, "R1 reset outputs",
            {29'b0, ready, done, res_we}, 32'h4);
        run_op(5'd0, 5'd7, 4'd5, 5'd0, 5'd1, 16'h0);   // R1 zero vector
        run_op(5'd2, 5'd0, 4'd0, 5'd2, 5'd1, 16'h0);   // R1 zero flag

        // R3 R6 directed move-in/out, byte 0 is MSB
        run_op(5'd4, 5'd1, 4'd0, 5'd0, 5'd0, 16'hA15B);
        run_op(5'd0, 5'd1, 4'd0, 5'd0, 5'd9, 16'h0);
        run_op(5'd0, 5'd1, 4'd1, 5'd0, 5'd9, 16'h0);
        // R7 wrap at byte 15
        run_op(5'd4, 5'd2, 4'd15, 5'd0, 5'd0, 16'h8C3D);
        run_op(5'd0, 5'd2, 4'd15, 5'd0, 5'd4, 16'h0);
        run_op(5'd0, 5'd2, 4'd14, 5'd0, 5'd4, 16'h0);
        run_op(5'd0, 5'd2, 4'd0, 5'd0, 5'd4, 16'h0);
        // R4 positive value, R5 zero destination
        run_op(5'd4, 5'd3, 4'd6, 5'd0, 5'd0, 16'h7FFE);
        run_op(5'd0, 5'd3, 4'd6, 5'd0, 5'd0, 16'h0);
        run_op(5'd0, 5'd3, 4'd6, 5'd0, 5'd31, 16'h0);
        // R8 R9 flag with bit 15 set, zero-extended
        run_op(5'd6, 5'd0, 4'd0, 5'd1, 5'd0, 16'hF00D);
        run_op(5'd2, 5'd0, 4'd0, 5'd1, 5'd2, 16'h0);
        // R10 out-of-range flag write and read
        run_op(5'd6, 5'd0, 4'd0, 5'd4, 5'd0, 16'h1234);
        run_op(5'd6, 5'd0, 4'd0, 5'd31, 5'd0, 16'h5678);
        run_op(5'd2, 5'd0, 4'd0, 5'd5, 5'd2, 16'h0);
        read_flags_all();
        // R2 illegal codes
        run_op(5'd1, 5'd1, 4'd0, 5'd0, 5'd1, 16'hFFFF);
        run_op(5'd8, 5'd1, 4'd0, 5'd0, 5'd1, 16'hFFFF);
        run_op(5'd0, 5'd1, 4'd0, 5'd0, 5'd9, 16'h0);

        // Random mix on a few registers for overlap (R3 R6 R8)
        for (int i = 0; i < 400; i++) begin
            logic [4:0] c;
            int k = int'($urandom_range(0, 9));
            c = (k < 4) ? 5'd4 : (k < 7) ? 5'd0 : (k == 7) ? 5'd6 :
                (k == 8) ? 5'd2 : 5'($urandom_range(0, 31));
            run_op(c, 5'($urandom_range(0, 3)), 4'($urandom), 5'($urandom_range(0, 5)),
                   5'($urandom_range(0, 3)), 16'($urandom));
        end
        // R6 full sweep: every byte pair of the touched registers
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 16; e++) run_op(5'd0, 5'(r), 4'(e), 5'd0, 5'd1, 16'h0);
        read_flags_all();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule